// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of small saturating counters. Several counters belong to each branch address slot, and the recent global outcome history picks which one of them is used. The branch predictor can therefore learn patterns where one branch's direction depends on how the branches before it went. With m history bits, the decision draws on m+1 branches: the m recorded ones plus the branch being predicted.

Fetch presents a PC on the lookup port and gets a taken/not-taken bit back in the same cycle. The caller also reads the current history from `ghist_o` at that moment and carries it down the pipe with the branch. When the branch resolves, the caller presents the PC, the real outcome and that saved history on the update port. The block trains the counter the prediction came from and shifts the outcome into the history register. The defaults give two history bits, two-bit counters and four PC index bits. Setting `IDX_ADDR_W` to 8 gives 1024 counters.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds the weakly-not-taken value (binary 01 for 2-bit counters), so every lookup predicts not taken, and `ghist_o` is all zeros.
- R2: `lookup_taken` is the MSB of the counter at index {lookup_pc[2+IDX_ADDR_W-1:2], ghist_o}, where the history bits are the low index bits. A 1 means taken. The output is combinational within the cycle.
- R3: An update with `upd_taken`=1 increments the selected counter, and the counter saturates at its all-ones value.
- R4: An update with `upd_taken`=0 decrements the selected counter, and the counter saturates at zero.
- R5: Each cycle with `upd_valid`=1 shifts `ghist_o` left by one and places `upd_taken` in bit 0, so bit 0 is the newest outcome. Without `upd_valid` the history holds its value.
- R6: The counter trained by an update is selected with `upd_hist`, not with the current history.
- R7: An update changes only the counter it selects. Counters for the same address under other histories, and counters for other addresses, keep their values.
- R8: PC bits below bit 2 and above bit 2+IDX_ADDR_W-1 have no effect on lookup or update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_pc | input | PC_W | Fetch PC to predict |
| lookup_taken | output | 1 | Predicted direction, 1 = taken |
| ghist_o | output | HIST_W | Current global history, newest outcome in bit 0 |
| upd_valid | input | 1 | Resolved branch present this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_hist | input | HIST_W | History captured when the branch was predicted |

## Verification
The hardest case to reach from the ports is reading back one counter that was trained under a chosen history. A lookup always uses the live history, and every update also shifts that history. The directed sequences therefore train a counter with an explicit `upd_hist`, then issue filler updates on an unrelated address whose outcomes steer the live history back to the wanted value before the lookup. Saturation at both ends is shown by overshooting: extra taken or not-taken updates are followed by the single opposite update whose result differs between a saturating counter and a wrapping one. A long pseudo-random update run with arbitrary saved histories and scrambled PC bits then checks all sixteen address slots after every update against an arithmetic table model.

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int HIST_W     = 2,
  parameter int CTR_W      = 2,
  parameter int IDX_ADDR_W = 4,
  parameter int PC_W       = 32,
  parameter int PC_LSB     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lookup_pc,
  output logic              lookup_taken,
  output logic [HIST_W-1:0] ghist_o,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);
  localparam int IDX_W    = IDX_ADDR_W + HIST_W;
  localparam int DEPTH    = 1 << IDX_W;
  localparam int CTR_MAX  = (1 << CTR_W) - 1;
  localparam int CTR_INIT = (1 << (CTR_W - 1)) - 1;

  logic [CTR_W-1:0]  ctr_q [DEPTH];
  logic [HIST_W-1:0] hist_q;

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [CTR_W-1:0] up_cur, up_nxt;
  logic [HIST_W:0]  hist_ext;

  assign lk_idx = {lookup_pc[PC_LSB +: IDX_ADDR_W], hist_q};
  assign up_idx = {upd_pc[PC_LSB +: IDX_ADDR_W], upd_hist};

  assign lookup_taken = ctr_q[lk_idx][CTR_W-1];
  assign ghist_o      = hist_q;

  assign up_cur   = ctr_q[up_idx];
  assign hist_ext = {hist_q, upd_taken};

  always_comb begin
    up_nxt = up_cur;
    if (upd_taken) begin
      if (up_cur != CTR_W'(CTR_MAX)) up_nxt = up_cur + 1'b1;
    end else begin
      if (up_cur != '0) up_nxt = up_cur - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_W'(CTR_INIT);
    end else if (upd_valid) begin
      hist_q        <= hist_ext[HIST_W-1:0];
      ctr_q[up_idx] <= up_nxt;
    end
  end

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lookup_pc, upd_pc};
endmodule

module corr_bpred_chk #(
  parameter int HIST_W     = 2,
  parameter int CTR_W      = 2,
  parameter int IDX_ADDR_W = 4,
  parameter int PC_W       = 32,
  parameter int PC_LSB     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   lookup_pc,
  input logic              lookup_taken,
  input logic [HIST_W-1:0] ghist_o,
  input logic              upd_valid,
  input logic [PC_W-1:0]   upd_pc,
  input logic              upd_taken,
  input logic [HIST_W-1:0] upd_hist,
  input logic [CTR_W-1:0]  ctr_q [1 << (IDX_ADDR_W + HIST_W)]
);
  localparam int IDX_W = IDX_ADDR_W + HIST_W;
  localparam logic [CTR_W-1:0] MAXV = '1;

  logic [IDX_W-1:0] c_uidx, c_lidx;
  logic [CTR_W-1:0] c_ucur;
  assign c_uidx = {upd_pc[PC_LSB +: IDX_ADDR_W], upd_hist};
  assign c_lidx = {lookup_pc[PC_LSB +: IDX_ADDR_W], ghist_o};
  assign c_ucur = ctr_q[c_uidx];

  a_r2_msb_predicts: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_taken == ctr_q[c_lidx][CTR_W-1]);

  a_r3_inc_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken) |=> ctr_q[$past(c_uidx)] ==
      (($past(c_ucur) == MAXV) ? MAXV : CTR_W'($past(c_ucur) + 1'b1)));

  a_r4_dec_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken) |=> ctr_q[$past(c_uidx)] ==
      (($past(c_ucur) == '0) ? '0 : CTR_W'($past(c_ucur) - 1'b1)));

  a_r5_newest_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ghist_o[0] == $past(upd_taken));

  a_r5_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist_o));
endmodule

bind corr_bpred corr_bpred_chk #(
  .HIST_W(HIST_W), .CTR_W(CTR_W), .IDX_ADDR_W(IDX_ADDR_W), .PC_W(PC_W), .PC_LSB(PC_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .lookup_taken(lookup_taken),
  .ghist_o(ghist_o), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
  .upd_hist(upd_hist), .ctr_q(ctr_q)
);

// File: tb/corr_bpred_bench.sv
module corr_bpred_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lookup_pc = 0;
  logic        lookup_taken;
  logic [1:0]  ghist_o;
  logic        upd_valid = 0;
  logic [31:0] upd_pc = 0;
  logic        upd_taken = 0;
  logic [1:0]  upd_hist = 0;

  always #4 clk = ~clk;

  corr_bpred u_corr_bpred (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .lookup_taken(lookup_taken),
    .ghist_o(ghist_o), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_hist(upd_hist)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  int m_ctr [64];
  int m_hist = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  function automatic logic [31:0] step(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] mkpc(int a, logic [31:0] junk);
    return {junk[31:6], 4'(a), junk[1:0]};
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic probe_all(string req);
    for (int a = 0; a < 16; a++) begin
      lfsr = step(lfsr);
      lookup_pc = mkpc(a, lfsr);
      #1;
      check(req, lookup_taken, (m_ctr[a*4 + m_hist] >= 2) ? 1 : 0);
    end
  endtask

  task automatic upd(int a, int h, bit t);
    @(negedge clk);
    lfsr = step(lfsr);
    upd_pc = mkpc(a, lfsr);
    upd_hist = 2'(h);
    upd_taken = t;
    upd_valid = 1;
    @(negedge clk);
    upd_valid = 0;
    if (t) begin if (m_ctr[a*4 + h] < 3) m_ctr[a*4 + h]++; end
    else   begin if (m_ctr[a*4 + h] > 0) m_ctr[a*4 + h]--; end
    m_hist = ((m_hist << 1) | int'(t)) & 3;
    check("R5 history shift", ghist_o, m_hist);
    probe_all("R2/R7/R8 table lookup");
  endtask

  task automatic look(string req, int a, int exp);
    lfsr = step(lfsr);
    lookup_pc = mkpc(a, lfsr);
    #1;
    check(req, lookup_taken, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) m_ctr[i] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset history", ghist_o, 0);
    probe_all("R1 reset weakly not taken");

    // R6: train (1,11) while live history is 00
    upd(1, 3, 1);
    upd(1, 3, 1);
    look("R6 saved history selects counter", 1, 1);

    // R3: overshoot the ceiling at (3,11)
    for (int k = 0; k < 5; k++) upd(3, 3, 1);
    upd(3, 3, 0);
    upd(6, 0, 1);
    upd(6, 0, 1);
    look("R3 saturate at max then one down stays taken", 3, 1);
    upd(3, 3, 0);
    upd(6, 0, 1);
    upd(6, 0, 1);
    look("R3 second down is not taken", 3, 0);

    // R4: overshoot the floor at (4,11)
    for (int k = 0; k < 3; k++) upd(4, 3, 0);
    upd(4, 3, 1);
    upd(6, 0, 1);
    look("R4 saturate at zero then one up stays not taken", 4, 0);
    upd(4, 3, 1);
    upd(6, 0, 1);
    look("R4 second up is taken", 4, 1);

    // R8: no-update cycles keep history, then a random sweep
    repeat (3) @(negedge clk);
    check("R5 history hold without update", ghist_o, m_hist);
    for (int n = 0; n < 400; n++) begin
      lfsr = step(lfsr);
      upd(int'(lfsr[7:4]), int'(lfsr[9:8]), lfsr[12] ^ lfsr[3]);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule